// File: doc/BRIEF.md
# Real-Time Clock with Bus-Side Snapshot

This block keeps wall-clock time as a seconds count and a milliseconds count. Both advance from a slow time-base strobe (`tick_32k`, one clock-enable pulse per cycle of a 32.768 kHz reference, with the reference rate as a parameter). The live counters are not read directly by the bus. Instead, every eighth strobe the block copies them into a pair of bus-visible registers. A busy flag is raised for the strobe interval that ends in that copy, so software can see when the copy is about to happen.

Software reads a consistent time pair by reading the milliseconds register first. That read also latches the bus-side seconds into a shadow register, and a later read of the shadow gives the matching seconds. Software sets the time by writing the seconds register. The new value is loaded at the next strobe and the milliseconds restart from zero.

Two seconds alarms and one milliseconds alarm compare against the live counters. Two external countdown events only set status bits. Status bits are cleared by writing one to them, and a mask selects which of them drive the single level-high interrupt line.

Top module: `rtc_snap_top`

## Requirements
- R1: After reset, every register reads 0 (busy 0x04, seconds 0x08, shadow 0x0C, milliseconds 0x10, alarms 0x14/0x18/0x1C, mask 0x28, status 0x2C), and `irq` is low.
- R2: Each strobe adds 1000 to a fraction accumulator modulo TICK_HZ. When the accumulator wraps, the live milliseconds advance by one. Milliseconds go from 999 back to 0, and that step increments the live seconds.
- R3: On strobe number n (counted since reset) with n a multiple of 8, the bus-side seconds (0x08) and milliseconds (0x10) take the live values from just before that strobe. Between such strobes they hold their value.
- R4: Busy (bit 0 of 0x04) reads 1 after strobe number n with n mod 8 = 7, up to the next strobe, and reads 0 at all other times.
- R5: A read of 0x10 stores the bus-side seconds in the shadow register (0x0C) on the same clock. A read on the clock of a copy strobe returns the pre-copy milliseconds and shadows the pre-copy seconds.
- R6: A write to 0x08 loads the live seconds at the next strobe and zeroes the milliseconds and the fraction. If that strobe is a copy strobe, the copy carries the values from before the load.
- R7: The alarm registers 0x14, 0x18 and 0x1C and the mask register 0x28 (bits 4:0) read back what was last written.
- R8: Status bit 0 (alarm 0x14) and bit 1 (alarm 0x18) are set on the strobe where the live seconds are updated to a value equal to a nonzero alarm. An alarm of 0 never matches.
- R9: Status bit 2 is set on the strobe where the live milliseconds are updated to a value equal to a nonzero value in 0x1C.
- R10: `cdown_hit[0]` sets status bit 3 and `cdown_hit[1]` sets status bit 4 on the clock where they are high.
- R11: Writing 0x2C clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. A set on the same clock wins over the clear.
- R12: `irq` is high exactly when some status bit and its mask bit are both 1, changing on the same clock edge as the status or mask.
- R13: Read data appears on `rdata` on the clock after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | One-clock strobe per reference time-base cycle |
| cdown_hit | input | 2 | Countdown events for status bits 3 and 4 |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level-high interrupt |

## Verification
Two functions can meet on one clock: a milliseconds read landing on the strobe that performs the snapshot copy. The bench aligns the strobe count so the next strobe is a copy strobe, then issues the read together with that strobe. It expects the pre-copy milliseconds, then a shadow equal to the pre-copy seconds, then the refreshed milliseconds on a later read. The same approach is used when a seconds write is pending into a copy strobe, and when a countdown event coincides with a write-one clear of its own status bit.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  // register byte offsets (software decodes these)
  localparam int OFS_BUSY   = 'h04;
  localparam int OFS_SEC    = 'h08;
  localparam int OFS_SHADOW = 'h0C;
  localparam int OFS_MSEC   = 'h10;
  localparam int OFS_SALM0  = 'h14;  // seconds alarms at 0x14 + 4*i
  localparam int OFS_MALM   = 'h1C;
  localparam int OFS_MASK   = 'h28;
  localparam int OFS_STAT   = 'h2C;

  // event layout: seconds alarms, then ms alarm, then countdowns
  localparam int SALM_N = 2;
  localparam int CDN_N  = 2;
  localparam int EVT_N  = SALM_N + 1 + CDN_N;
  localparam int EV_MALM = SALM_N;
endpackage

// File: rtl/rtc_snap_timebase.sv
module rtc_snap_timebase #(
  parameter int TICK_HZ  = 32768,
  parameter int MS_PER_S = 1000,
  parameter int SEC_W    = 32,
  parameter int MS_W     = 10,
  parameter int COPY_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ld_req,
  input  logic [SEC_W-1:0] ld_val,
  output logic [SEC_W-1:0] sec_live,
  output logic [SEC_W-1:0] sec_nxt,
  output logic [SEC_W-1:0] bus_sec,
  output logic [MS_W-1:0]  ms_live,
  output logic [MS_W-1:0]  ms_nxt,
  output logic [MS_W-1:0]  bus_ms,
  output logic             sec_upd,
  output logic             ms_upd,
  output logic             busy,
  output logic             pend
);
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_S) + 1;
  localparam int PH_W  = (COPY_DIV > 1) ? $clog2(COPY_DIV) : 1;
  localparam logic [ACC_W-1:0] ACC_INC = ACC_W'(MS_PER_S);
  localparam logic [ACC_W-1:0] ACC_MOD = ACC_W'(TICK_HZ);
  localparam logic [MS_W-1:0]  MS_LAST = MS_W'(MS_PER_S - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(COPY_DIV - 1);

  logic [ACC_W-1:0] acc_q, acc_sum, acc_nxt;
  logic [MS_W-1:0]  ms_q, bms_q;
  logic [SEC_W-1:0] sec_q, bsec_q, pval_q;
  logic [PH_W-1:0]  ph_q, ph_nxt;
  logic             pend_q, busy_q, step, wrap;

  always_comb begin
    acc_sum = acc_q + ACC_INC;
    step    = (acc_sum >= ACC_MOD);
    wrap    = step && (ms_q == MS_LAST);
    if (pend_q) begin
      acc_nxt = '0;
      ms_nxt  = '0;
      sec_nxt = pval_q;
    end else begin
      acc_nxt = step ? (acc_sum - ACC_MOD) : acc_sum;
      ms_nxt  = step ? (wrap ? '0 : ms_q + 1'b1) : ms_q;
      sec_nxt = wrap ? sec_q + 1'b1 : sec_q;
    end
    ph_nxt  = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    sec_upd = tick && (pend_q || wrap);
    ms_upd  = tick && (pend_q || step);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      ms_q   <= '0;
      sec_q  <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
      bsec_q <= '0;
      bms_q  <= '0;
      pend_q <= 1'b0;
      pval_q <= '0;
    end else begin
      if (tick) begin
        acc_q  <= acc_nxt;
        ms_q   <= ms_nxt;
        sec_q  <= sec_nxt;
        ph_q   <= ph_nxt;
        busy_q <= (ph_nxt == PH_LAST);
        if (ph_q == PH_LAST) begin
          bsec_q <= sec_q;
          bms_q  <= ms_q;
        end
      end
      if (ld_req) begin
        pend_q <= 1'b1;
        pval_q <= ld_val;
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign sec_live = sec_q;
  assign ms_live  = ms_q;
  assign bus_sec  = bsec_q;
  assign bus_ms   = bms_q;
  assign busy     = busy_q;
  assign pend     = pend_q;
endmodule

// File: rtl/rtc_snap_events.sv
module rtc_snap_events
  import rtc_snap_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sec_upd,
  input  logic [SEC_W-1:0]             sec_nxt,
  input  logic                         ms_upd,
  input  logic [MS_W-1:0]              ms_nxt,
  input  logic [SALM_N-1:0][SEC_W-1:0] salm,
  input  logic [DATA_W-1:0]            malm,
  input  logic [CDN_N-1:0]             cdown_hit,
  input  logic [EVT_N-1:0]             clr,
  input  logic                         mask_we,
  input  logic [EVT_N-1:0]             mask_wval,
  output logic [EVT_N-1:0]             status,
  output logic [EVT_N-1:0]             mask,
  output logic [EVT_N-1:0]             set_vec,
  output logic                         irq
);
  logic [EVT_N-1:0] st_q, mk_q, st_nxt, mk_nxt;
  logic             irq_q;
  logic [DATA_W-1:0] ms_ext;

  assign ms_ext = {{(DATA_W-MS_W){1'b0}}, ms_nxt};

  genvar g;
  generate
    for (g = 0; g < SALM_N; g++) begin : g_salm
      assign set_vec[g] = sec_upd && (salm[g] != '0) && (sec_nxt == salm[g]);
    end
  endgenerate

  assign set_vec[EV_MALM]             = ms_upd && (malm != '0) && (ms_ext == malm);
  assign set_vec[EVT_N-1:EV_MALM+1]   = cdown_hit;

  always_comb begin
    st_nxt = (st_q & ~clr) | set_vec;
    mk_nxt = mask_we ? mask_wval : mk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      mk_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      mk_q  <= mk_nxt;
      irq_q <= |(st_nxt & mk_nxt);
    end
  end

  assign status = st_q;
  assign mask   = mk_q;
  assign irq    = irq_q;
endmodule

// File: rtl/rtc_snap_regs.sv
module rtc_snap_regs
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [SEC_W-1:0]             bus_sec,
  input  logic [MS_W-1:0]              bus_ms,
  input  logic                         busy,
  input  logic [EVT_N-1:0]             status,
  input  logic [EVT_N-1:0]             mask,
  output logic [DATA_W-1:0]            rdata,
  output logic                         ld_req,
  output logic [SEC_W-1:0]             ld_val,
  output logic [SALM_N-1:0][SEC_W-1:0] salm,
  output logic [DATA_W-1:0]            malm,
  output logic [EVT_N-1:0]             clr,
  output logic                         mask_we,
  output logic [EVT_N-1:0]             mask_wval
);
  logic [SALM_N-1:0][SEC_W-1:0] salm_q;
  logic [DATA_W-1:0] malm_q, rd_mux, rdata_q;
  logic [SEC_W-1:0]  shadow_q;
  logic              hit_msec, hit_stat;

  assign hit_msec = (addr == ADDR_W'(OFS_MSEC));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(OFS_BUSY):   rd_mux = DATA_W'(busy);
      ADDR_W'(OFS_SEC):    rd_mux = DATA_W'(bus_sec);
      ADDR_W'(OFS_SHADOW): rd_mux = DATA_W'(shadow_q);
      ADDR_W'(OFS_MSEC):   rd_mux = DATA_W'(bus_ms);
      ADDR_W'(OFS_MALM):   rd_mux = malm_q;
      ADDR_W'(OFS_MASK):   rd_mux = DATA_W'(mask);
      ADDR_W'(OFS_STAT):   rd_mux = DATA_W'(status);
      default:             rd_mux = '0;
    endcase
    for (int i = 0; i < SALM_N; i++) begin
      if (addr == ADDR_W'(OFS_SALM0 + 4*i)) rd_mux = DATA_W'(salm_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      salm_q   <= '0;
      malm_q   <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (rd_en) begin
        rdata_q <= rd_mux;
        if (hit_msec) shadow_q <= bus_sec;
      end
      if (wr_en) begin
        for (int i = 0; i < SALM_N; i++) begin
          if (addr == ADDR_W'(OFS_SALM0 + 4*i)) salm_q[i] <= wdata[SEC_W-1:0];
        end
        if (addr == ADDR_W'(OFS_MALM)) malm_q <= wdata;
      end
    end
  end

  assign ld_req    = wr_en && (addr == ADDR_W'(OFS_SEC));
  assign ld_val    = wdata[SEC_W-1:0];
  assign clr       = (wr_en && hit_stat) ? wdata[EVT_N-1:0] : '0;
  assign mask_we   = wr_en && (addr == ADDR_W'(OFS_MASK));
  assign mask_wval = wdata[EVT_N-1:0];
  assign salm      = salm_q;
  assign malm      = malm_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/rtc_snap_top.sv
module rtc_snap_top
  import rtc_snap_pkg::*;
#(
  parameter int TICK_HZ  = 32768,
  parameter int MS_PER_S = 1000,
  parameter int COPY_DIV = 8,
  parameter int SEC_W    = 32,
  parameter int MS_W     = 10,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_32k,
  input  logic [1:0]        cdown_hit,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [SEC_W-1:0] sec_live_w, sec_nxt_w, bus_sec_w, ld_val_w;
  logic [MS_W-1:0]  ms_live_w, ms_nxt_w, bus_ms_w;
  logic             sec_upd_w, ms_upd_w, busy_w, pend_w, ld_req_w, mask_we_w;
  logic [SALM_N-1:0][SEC_W-1:0] salm_w;
  logic [DATA_W-1:0] malm_w;
  logic [EVT_N-1:0]  status_w, mask_w, set_w, clr_w, mask_wval_w;

  rtc_snap_timebase #(
    .TICK_HZ(TICK_HZ), .MS_PER_S(MS_PER_S), .SEC_W(SEC_W),
    .MS_W(MS_W), .COPY_DIV(COPY_DIV)
  ) u_tb (
    .clk(clk), .rst(rst), .tick(tick_32k),
    .ld_req(ld_req_w), .ld_val(ld_val_w),
    .sec_live(sec_live_w), .sec_nxt(sec_nxt_w), .bus_sec(bus_sec_w),
    .ms_live(ms_live_w), .ms_nxt(ms_nxt_w), .bus_ms(bus_ms_w),
    .sec_upd(sec_upd_w), .ms_upd(ms_upd_w), .busy(busy_w), .pend(pend_w)
  );

  rtc_snap_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .MS_W(MS_W)
  ) u_regs (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .bus_sec(bus_sec_w), .bus_ms(bus_ms_w), .busy(busy_w),
    .status(status_w), .mask(mask_w), .rdata(rdata),
    .ld_req(ld_req_w), .ld_val(ld_val_w), .salm(salm_w), .malm(malm_w),
    .clr(clr_w), .mask_we(mask_we_w), .mask_wval(mask_wval_w)
  );

  rtc_snap_events #(
    .SEC_W(SEC_W), .MS_W(MS_W), .DATA_W(DATA_W)
  ) u_evt (
    .clk(clk), .rst(rst), .sec_upd(sec_upd_w), .sec_nxt(sec_nxt_w),
    .ms_upd(ms_upd_w), .ms_nxt(ms_nxt_w), .salm(salm_w), .malm(malm_w),
    .cdown_hit(cdown_hit), .clr(clr_w), .mask_we(mask_we_w),
    .mask_wval(mask_wval_w), .status(status_w), .mask(mask_w),
    .set_vec(set_w), .irq(irq)
  );
endmodule

// File: rtl/rtc_snap_chk.sv
module rtc_snap_chk #(
  parameter int MS_PER_S = 1000,
  parameter int MS_W     = 10,
  parameter int SEC_W    = 32,
  parameter int EVT_N    = 5,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              busy,
  input logic              pend,
  input logic [MS_W-1:0]   ms_live,
  input logic [EVT_N-1:0]  status,
  input logic [EVT_N-1:0]  mask,
  input logic [EVT_N-1:0]  set_vec,
  input logic              irq,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [SEC_W-1:0]  salm0
);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

  a_r2_ms_in_range: assert property (@(posedge clk) disable iff (rst)
    ms_live <= MS_LAST);

  a_r4_busy_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(busy));

  a_r6_load_zeroes_ms: assert property (@(posedge clk) disable iff (rst)
    (tick && pend) |=> (ms_live == '0));

  a_r8_zero_alarm_silent: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> ($past(salm0) != '0));

  a_r11_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h2C) && set_vec == '0)
      |=> ((status & $past(wdata[EVT_N-1:0])) == '0));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  a_r12_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == |(status & mask));
endmodule

bind rtc_snap_top rtc_snap_chk #(
  .MS_PER_S(MS_PER_S), .MS_W(MS_W), .SEC_W(SEC_W),
  .EVT_N(rtc_snap_pkg::EVT_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick_32k), .busy(busy_w), .pend(pend_w),
  .ms_live(ms_live_w), .status(status_w), .mask(mask_w), .set_vec(set_w),
  .irq(irq), .wr_en(wr_en), .addr(addr), .wdata(wdata), .salm0(salm_w[0])
);

// File: tb/rtc_snap_top_tb.sv
module rtc_snap_top_tb;
  import rtc_snap_pkg::*;
  localparam int HZ  = 2000;
  localparam int DIV = 8;

  logic        clk = 1'b0, rst = 1'b1, tick_32k = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  cdown_hit = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  rtc_snap_top #(.TICK_HZ(HZ), .COPY_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .cdown_hit(cdown_hit),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0;
  bit rd_seen = 0, done = 0;

  // model state, built from the requirements
  longint tick_n = 0, ld_tick = 0, ld_val = 0, pval = 0;
  bit     pend = 0;
  longint bsec = 0, bms = 0, shadow = 0;
  longint alm[3] = '{0, 0, 0};
  logic [4:0] mk = '0, st = '0;

  function automatic longint tot_ms(longint t);
    return ((t - ld_tick) * 1000) / HZ;
  endfunction
  function automatic longint live_sec(longint t);
    return ld_val + tot_ms(t) / 1000;
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (int'(a))
      OFS_BUSY:   return 32'((tick_n % DIV) == DIV - 1);
      OFS_SEC:    return 32'(bsec);
      OFS_SHADOW: return 32'(shadow);
      OFS_MSEC:   return 32'(bms);
      'h14:       return 32'(alm[0]);
      'h18:       return 32'(alm[1]);
      OFS_MALM:   return 32'(alm[2]);
      OFS_MASK:   return 32'(mk);
      OFS_STAT:   return 32'(st);
      default:    return 32'h0;
    endcase
  endfunction

  // R13 scoreboard monitor: rdata compared one clock after rd_en
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic cycle(bit tk, bit rd, bit wr, logic [7:0] a, logic [31:0] wd,
                       logic [1:0] cd, string tag);
    logic [4:0] set, clr;
    longint s0, m0, s1, m1;
    bit supd, mupd;
    @(negedge clk);
    tick_32k = tk; rd_en = rd; wr_en = wr; addr = a; wdata = wd; cdown_hit = cd;
    if (rd) begin
      item_t it;
      it.exp = model_read(a);
      it.tag = tag;
      sb.push_back(it);
      if (int'(a) == OFS_MSEC) shadow = bsec;
    end
    set = '0; clr = '0;
    if (tk) begin
      s0 = live_sec(tick_n); m0 = tot_ms(tick_n);
      supd = 0; mupd = 0;
      if (((tick_n + 1) % DIV) == 0) begin bsec = s0; bms = m0 % 1000; end
      tick_n = tick_n + 1;
      if (pend) begin
        ld_tick = tick_n; ld_val = pval; pend = 0; supd = 1; mupd = 1;
      end else begin
        m1 = tot_ms(tick_n);
        mupd = (m1 != m0);
        supd = ((m1 / 1000) != (m0 / 1000));
      end
      s1 = live_sec(tick_n); m1 = tot_ms(tick_n) % 1000;
      for (int i = 0; i < 2; i++)
        if (supd && alm[i] != 0 && s1 == alm[i]) set[i] = 1'b1;
      if (mupd && alm[2] != 0 && m1 == alm[2]) set[2] = 1'b1;
    end
    set[4:3] = cd;
    if (wr) begin
      case (int'(a))
        OFS_SEC:  begin pend = 1; pval = longint'(wd); end
        'h14:     alm[0] = longint'(wd);
        'h18:     alm[1] = longint'(wd);
        OFS_MALM: alm[2] = longint'(wd);
        OFS_MASK: mk = wd[4:0];
        OFS_STAT: clr = wd[4:0];
        default: ;
      endcase
    end
    st = (st & ~clr) | set;
    @(posedge clk);
    #1 tick_32k = 0; rd_en = 0; wr_en = 0; cdown_hit = '0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    cycle(0, 1, 0, a, '0, '0, tag);
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d);
    cycle(0, 0, 1, a, d, '0, "");
  endtask
  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      cycle(1, 0, 0, '0, '0, '0, "");
      cycle(0, 0, 0, '0, '0, '0, "");
    end
  endtask
  task automatic align(int ph);
    while ((tick_n % DIV) != ph) run_ticks(1);
  endtask
  task automatic chk_irq(string tag);
    @(negedge clk);
    checks++;
    if (irq !== |(st & mk)) begin
      errors++;
      $display("FAIL %s: irq=%0b expected=%0b", tag, irq, |(st & mk));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset values
    rd(8'h04, "R1 busy"); rd(8'h08, "R1 sec"); rd(8'h0C, "R1 shadow");
    rd(8'h10, "R1 msec"); rd(8'h14, "R1 alarm0"); rd(8'h18, "R1 alarm1");
    rd(8'h1C, "R1 ms alarm"); rd(8'h28, "R1 mask"); rd(8'h2C, "R1 status");
    chk_irq("R1 irq");

    // R2/R3 free run and snapshot
    run_ticks(20);
    rd(8'h10, "R3 msec snapshot"); rd(8'h0C, "R5 shadow"); rd(8'h08, "R3 sec snapshot");

    // R4 busy window
    align(DIV - 1); rd(8'h04, "R4 busy high");
    run_ticks(1);   rd(8'h04, "R4 busy low");

    // R6 set time, R2 seconds roll over
    wr(8'h08, 32'd100);
    run_ticks(9);   rd(8'h08, "R6 sec loaded"); rd(8'h10, "R6 msec restarted");
    run_ticks(2000); rd(8'h08, "R2 sec advanced"); rd(8'h10, "R2 msec");

    // R6 write pending into a copy strobe
    align(DIV - 1); wr(8'h08, 32'd5000);
    run_ticks(1);   rd(8'h08, "R6 copy shows old sec");
    run_ticks(DIV); rd(8'h08, "R6 new sec after copy"); rd(8'h10, "R6 msec after load");

    // R5 msec read on the copy strobe
    run_ticks(30);
    align(DIV - 1);
    cycle(1, 1, 0, 8'h10, '0, '0, "R5 read at copy strobe");
    rd(8'h0C, "R5 shadow pre-copy"); rd(8'h10, "R5 msec post-copy");

    // R7 readback
    wr(8'h14, 32'(live_sec(tick_n) + 1)); wr(8'h18, 32'd0);
    wr(8'h1C, 32'd500); wr(8'h28, 32'h07);
    rd(8'h14, "R7 alarm0"); rd(8'h18, "R7 alarm1");
    rd(8'h1C, "R7 ms alarm"); rd(8'h28, "R7 mask");
    rd(8'h2C, "R8 status before"); chk_irq("R12 irq idle");

    // R8/R9 alarms fire, R12 interrupt
    run_ticks(2100);
    rd(8'h2C, "R8 R9 status after"); chk_irq("R12 irq raised");
    checks++;
    if (st[1] !== 1'b0 || st[0] !== 1'b1 || st[2] !== 1'b1) begin
      errors++;
      $display("FAIL R8 R9 model status=%b expected=x101", st);
    end

    // R11 write-one-to-clear
    wr(8'h2C, 32'h0);  rd(8'h2C, "R11 zero write keeps");
    wr(8'h2C, 32'h01); rd(8'h2C, "R11 bit0 cleared"); chk_irq("R12 irq still");
    wr(8'h2C, 32'h04); rd(8'h2C, "R11 bit2 cleared"); chk_irq("R12 irq dropped");

    // R10 countdown events, R11 set wins over clear
    cycle(0, 0, 1, 8'h2C, 32'h08, 2'b01, "");
    rd(8'h2C, "R10 R11 set wins"); chk_irq("R12 masked bit3");
    wr(8'h28, 32'h18); chk_irq("R12 mask enables");
    cycle(0, 0, 0, '0, '0, 2'b10, "");
    rd(8'h2C, "R10 bit4 set");
    wr(8'h2C, 32'h1F); rd(8'h2C, "R11 all cleared"); chk_irq("R12 irq low");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule